// File: doc/BRIEF.md
# Generation-Bit Completion Ring Reader

This block drains completion entries from a power-of-two ring that an external producer fills. It keeps no copy of the producer's position. Instead it runs a free-running read pointer that is one bit wider than the ring index. The bit above the index tells the block which generation value a fresh entry must carry. An entry counts as new only when bit 10 of its header holds that value. Old entries left over from the previous lap therefore look stale without any extra signalling.

A small side queue lets software inject completions of its own. When the output slot is refilled, a waiting side-queue entry always wins over the ring. The chosen entry is held in a registered output slot. Its header fields are decoded onto separate ports and handed over with a valid/ready handshake.

The producer writes ring words through a simple write port. Before it releases reset, the producer must fill every ring slot with generation 0.

Top module: `cqr_reader`

## Requirements
- R1: After reset, out_valid is 0, side_overflow is 0 and side_free equals the side-queue capacity (2^SIDE_LOG2).
- R2: The read pointer is RING_LOG2+1 bits wide, and the ring index is its low RING_LOG2 bits. The expected generation is the inverse of pointer bit RING_LOG2, so it is 1 on the first lap. A ring entry is accepted only when header bit 10 equals this expected value.
- R3: A ring entry whose generation bit does not match is never presented, and the read pointer stays on it. When the producer later writes that index with the right generation, that entry comes out next.
- R4: Once the pointer has passed all 2^RING_LOG2 slots, the expected generation becomes 0. Entries that still carry generation 1 from the first lap are then treated as stale.
- R5: When the output slot is loaded and the side queue holds an entry, the side entry is taken ahead of any valid ring entry. out_from_side is 1 for side entries and 0 for ring entries.
- R6: Side-queue entries come out in the order they were written.
- R7: A side write made while the side queue already holds 2^SIDE_LOG2 entries is dropped. side_overflow is then 1 for the single following cycle.
- R8: While out_valid is 1 and out_ready is 0, the presented entry and out_valid hold steady. Each cycle in which both are 1 consumes exactly one entry.
- R9: Header decode places the fields as follows:
  - opcode in bits 3:0
  - out_is_sq in bit 4 (1 = send-side completion, 0 = receive-side)
  - status in bits 9:5
  - generation in bit 10
  - software flag in bit 11
  - queue-pair id in bits 30:12
  - out-of-order flag in bit 31
- R10: Valid ring entries come out in ascending index order. Taking an entry advances only the pointer of the queue that supplied it.
- R11: side_free equals the capacity minus the side-queue occupancy, where occupancy is the write pointer minus the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_we | input | 1 | Producer write strobe for the ring |
| ring_idx | input | RING_LOG2 | Ring slot being written |
| ring_data | input | 32 | Completion header written to the ring |
| side_we | input | 1 | Software injection strobe |
| side_data | input | 32 | Injected completion header |
| side_overflow | output | 1 | Pulses when an injection is dropped |
| side_free | output | SIDE_LOG2+1 | Free side-queue slots |
| out_valid | output | 1 | Output slot holds an entry |
| out_ready | input | 1 | Consumer accepts the entry |
| out_from_side | output | 1 | Entry came from the side queue |
| out_opcode | output | 4 | Decoded opcode |
| out_is_sq | output | 1 | Send-side completion type |
| out_status | output | 5 | Decoded status |
| out_gen | output | 1 | Generation bit of the entry |
| out_swflag | output | 1 | Software-entry flag |
| out_qpid | output | 19 | Queue-pair id |
| out_ooo | output | 1 | Out-of-order flag |

## Verification
The hardest case to reach is the wrap. Stale first-lap entries must be refused only after the pointer has gone all the way round, so the bench has to consume exactly one full ring's worth of entries first. It does so by handing out ring slots in order across its scenarios and then filling and draining the remaining slots in one pass. After that pass it checks that nothing is presented, and that a generation-0 entry at slot 0 is accepted. Side priority is reached by writing a ring entry and a side entry on the same edge while the output slot is empty. The overflow case is reached by holding out_ready low until the side queue is full.

// File: rtl/cqr_pkg.sv
package cqr_pkg;
  localparam int WORD_W  = 32;
  localparam int GEN_BIT = 10;

  typedef struct packed {
    logic        ooo;
    logic [18:0] qpid;
    logic        swflag;
    logic        gen;
    logic [4:0]  status;
    logic        is_sq;
    logic [3:0]  opcode;
  } cqe_hdr_t;
endpackage

// File: rtl/cqr_ring_store.sv
module cqr_ring_store #(
  parameter int RING_LOG2 = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [RING_LOG2-1:0]       wr_idx,
  input  logic [cqr_pkg::WORD_W-1:0] wr_data,
  input  logic                       adv,
  output logic [cqr_pkg::WORD_W-1:0] head_data,
  output logic                       head_valid
);
  localparam int DEPTH = 1 << RING_LOG2;
  localparam int PTR_W = RING_LOG2 + 1;

  logic [cqr_pkg::WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]           rptr;
  logic                       expect_gen;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)      rptr <= '0;
    else if (adv) rptr <= rptr + 1'b1;
  end

  assign expect_gen = ~rptr[RING_LOG2];
  assign head_data  = mem[rptr[RING_LOG2-1:0]];
  assign head_valid = (head_data[cqr_pkg::GEN_BIT] == expect_gen);

  // R3: the pointer only moves over an entry whose generation matched
  assert_adv_only_valid_R3: assert property (@(posedge clk) disable iff (rst)
    adv |-> head_valid);

  // R10: each advance moves the index by exactly one slot
  assert_index_step_R10: assert property (@(posedge clk) disable iff (rst)
    adv |=> (rptr[RING_LOG2-1:0] == $past(rptr[RING_LOG2-1:0]) + 1'b1));
endmodule

// File: rtl/cqr_side_fifo.sv
module cqr_side_fifo #(
  parameter int SIDE_LOG2 = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [cqr_pkg::WORD_W-1:0] wr_data,
  input  logic                       rd_en,
  output logic [cqr_pkg::WORD_W-1:0] head_data,
  output logic                       empty,
  output logic [SIDE_LOG2:0]         free_cnt,
  output logic                       refused
);
  localparam int DEPTH = 1 << SIDE_LOG2;
  localparam int PTR_W = SIDE_LOG2 + 1;
  localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);

  logic [cqr_pkg::WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]           wptr, rptr, occ;
  logic                       full, accept;

  assign occ      = wptr - rptr;
  assign full     = (occ == CAP);
  assign empty    = (wptr == rptr);
  assign accept   = wr_en && !full;
  assign free_cnt = CAP - occ;
  assign head_data = mem[rptr[SIDE_LOG2-1:0]];

  always_ff @(posedge clk) begin
    if (accept) mem[wptr[SIDE_LOG2-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      refused <= 1'b0;
    end else begin
      if (accept) wptr <= wptr + 1'b1;
      if (rd_en)  rptr <= rptr + 1'b1;
      refused <= wr_en && full;
    end
  end

  // R7: occupancy can never exceed the capacity
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    occ <= CAP);

  // R6: no read from an empty queue
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/cqr_reader.sv
module cqr_reader #(
  parameter int RING_LOG2 = 4,
  parameter int SIDE_LOG2 = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ring_we,
  input  logic [RING_LOG2-1:0] ring_idx,
  input  logic [31:0]          ring_data,
  input  logic                 side_we,
  input  logic [31:0]          side_data,
  output logic                 side_overflow,
  output logic [SIDE_LOG2:0]   side_free,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_from_side,
  output logic [3:0]           out_opcode,
  output logic                 out_is_sq,
  output logic [4:0]           out_status,
  output logic                 out_gen,
  output logic                 out_swflag,
  output logic [18:0]          out_qpid,
  output logic                 out_ooo
);
  import cqr_pkg::*;

  logic [WORD_W-1:0] ring_head, side_head, slot_word;
  logic              ring_valid, side_empty, ring_adv, side_rd, take;
  logic              slot_valid, slot_side;
  cqe_hdr_t          hdr;

  cqr_ring_store #(.RING_LOG2(RING_LOG2)) u_ring (
    .clk(clk), .rst(rst), .wr_en(ring_we), .wr_idx(ring_idx),
    .wr_data(ring_data), .adv(ring_adv),
    .head_data(ring_head), .head_valid(ring_valid)
  );

  cqr_side_fifo #(.SIDE_LOG2(SIDE_LOG2)) u_side (
    .clk(clk), .rst(rst), .wr_en(side_we), .wr_data(side_data),
    .rd_en(side_rd), .head_data(side_head), .empty(side_empty),
    .free_cnt(side_free), .refused(side_overflow)
  );

  assign take     = !slot_valid || out_ready;
  assign side_rd  = take && !side_empty;
  assign ring_adv = take && side_empty && ring_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= 1'b0;
      slot_side  <= 1'b0;
      slot_word  <= '0;
    end else if (take) begin
      slot_valid <= side_rd || ring_adv;
      if (side_rd) begin
        slot_word <= side_head;
        slot_side <= 1'b1;
      end else if (ring_adv) begin
        slot_word <= ring_head;
        slot_side <= 1'b0;
      end
    end
  end

  assign hdr           = cqe_hdr_t'(slot_word);
  assign out_valid     = slot_valid;
  assign out_from_side = slot_side;
  assign out_opcode    = hdr.opcode;
  assign out_is_sq     = hdr.is_sq;
  assign out_status    = hdr.status;
  assign out_gen       = hdr.gen;
  assign out_swflag    = hdr.swflag;
  assign out_qpid      = hdr.qpid;
  assign out_ooo       = hdr.ooo;

  // R8: a stalled entry stays presented and unchanged
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(slot_word) && $stable(out_from_side)));

  // R5: a ring entry is only taken when the side queue is empty
  assert_ring_after_side_R5: assert property (@(posedge clk) disable iff (rst)
    ring_adv |-> side_empty);

  // R7: a drop pulse follows a write into a queue with no free slot
  assert_drop_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    side_overflow |-> $past(side_we && side_free == '0));
endmodule

// File: tb/cqr_reader_test.sv
module cqr_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int RL = 4;
  localparam int SL = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ring_we = 1'b0;
  logic [RL-1:0] ring_idx = '0;
  logic [31:0]   ring_data = '0;
  logic          side_we = 1'b0;
  logic [31:0]   side_data = '0;
  logic          out_ready = 1'b0;
  logic          side_overflow, out_valid, out_from_side, out_is_sq;
  logic          out_gen, out_swflag, out_ooo;
  logic [SL:0]   side_free;
  logic [3:0]    out_opcode;
  logic [4:0]    out_status;
  logic [18:0]   out_qpid;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cqr_reader #(.RING_LOG2(RL), .SIDE_LOG2(SL)) uut (
    .clk(clk), .rst(rst), .ring_we(ring_we), .ring_idx(ring_idx),
    .ring_data(ring_data), .side_we(side_we), .side_data(side_data),
    .side_overflow(side_overflow), .side_free(side_free),
    .out_valid(out_valid), .out_ready(out_ready), .out_from_side(out_from_side),
    .out_opcode(out_opcode), .out_is_sq(out_is_sq), .out_status(out_status),
    .out_gen(out_gen), .out_swflag(out_swflag), .out_qpid(out_qpid), .out_ooo(out_ooo)
  );

  function automatic logic [31:0] mk(input logic ooo, input logic [18:0] qp,
                                     input logic sw, input logic g,
                                     input logic [4:0] st, input logic sq,
                                     input logic [3:0] op);
    return {ooo, qp, sw, g, st, sq, op};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ring_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    ring_we = 1'b1; ring_idx = RL'(idx); ring_data = d;
    @(negedge clk);
    ring_we = 1'b0;
  endtask

  task automatic side_write(input logic [31:0] d);
    @(negedge clk);
    side_we = 1'b1; side_data = d;
    @(negedge clk);
    side_we = 1'b0;
  endtask

  // waits for an entry, checks decoded fields (R9) and source, then consumes it
  task automatic pop_expect(input string req, input logic [31:0] exp, input logic src);
    int n = 0;
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
    check(req, {31'd0, out_valid, out_from_side,
                out_ooo, out_qpid, out_swflag, out_gen, out_status, out_is_sq, out_opcode},
               {31'd0, 1'b1, src, exp});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", 64'(out_valid), 64'd0);
    check("R1 overflow", 64'(side_overflow), 64'd0);
    check("R1 free", 64'(side_free), 64'd4);
  endtask

  task automatic t_ring_basic;
    ring_write(0, mk(1'b1, 19'h7FFFF, 1'b0, 1'b1, 5'h15, 1'b1, 4'h5));
    ring_write(1, mk(1'b0, 19'h12345, 1'b1, 1'b1, 5'h0A, 1'b0, 4'hC));
    pop_expect("R2 R9 slot0", mk(1'b1, 19'h7FFFF, 1'b0, 1'b1, 5'h15, 1'b1, 4'h5), 1'b0);
    pop_expect("R9 R10 slot1", mk(1'b0, 19'h12345, 1'b1, 1'b1, 5'h0A, 1'b0, 4'hC), 1'b0);
    repeat (2) @(negedge clk);
    check("R2 stale slot2 not shown", 64'(out_valid), 64'd0);
  endtask

  task automatic t_stale_hold;
    ring_write(3, mk(1'b0, 19'h00003, 1'b0, 1'b1, 5'h03, 1'b1, 4'h3));
    repeat (3) @(negedge clk);
    check("R3 pointer held on stale slot2", 64'(out_valid), 64'd0);
    ring_write(2, mk(1'b0, 19'h00002, 1'b0, 1'b1, 5'h02, 1'b0, 4'h2));
    pop_expect("R3 slot2 after refill", mk(1'b0, 19'h00002, 1'b0, 1'b1, 5'h02, 1'b0, 4'h2), 1'b0);
    pop_expect("R10 slot3 in order", mk(1'b0, 19'h00003, 1'b0, 1'b1, 5'h03, 1'b1, 4'h3), 1'b0);
  endtask

  task automatic t_backpressure;
    ring_write(4, mk(1'b1, 19'h00444, 1'b0, 1'b1, 5'h1F, 1'b1, 4'hF));
    ring_write(5, mk(1'b0, 19'h00555, 1'b0, 1'b1, 5'h01, 1'b0, 4'h1));
    repeat (5) @(negedge clk);
    check("R8 held entry", {32'd0, out_valid, out_ooo, out_qpid, out_status, out_opcode},
          {32'd0, 1'b1, 1'b1, 19'h00444, 5'h1F, 4'hF});
    pop_expect("R8 slot4", mk(1'b1, 19'h00444, 1'b0, 1'b1, 5'h1F, 1'b1, 4'hF), 1'b0);
    pop_expect("R8 slot5", mk(1'b0, 19'h00555, 1'b0, 1'b1, 5'h01, 1'b0, 4'h1), 1'b0);
  endtask

  task automatic t_priority;
    @(negedge clk);
    ring_we = 1'b1; ring_idx = RL'(6);
    ring_data = mk(1'b0, 19'h00666, 1'b0, 1'b1, 5'h06, 1'b1, 4'h6);
    side_we = 1'b1; side_data = mk(1'b0, 19'h0ABCD, 1'b1, 1'b0, 5'h0C, 1'b0, 4'h9);
    @(negedge clk);
    ring_we = 1'b0; side_we = 1'b0;
    pop_expect("R5 side first", mk(1'b0, 19'h0ABCD, 1'b1, 1'b0, 5'h0C, 1'b0, 4'h9), 1'b1);
    pop_expect("R5 ring second", mk(1'b0, 19'h00666, 1'b0, 1'b1, 5'h06, 1'b1, 4'h6), 1'b0);
  endtask

  task automatic t_overflow;
    side_write(32'h0000_0A01);
    @(negedge clk);
    check("R11 free with head in slot", 64'(side_free), 64'd4);
    for (int i = 2; i <= 5; i++) side_write(32'h0000_0A00 + 32'(i));
    check("R11 free when full", 64'(side_free), 64'd0);
    check("R7 no drop yet", 64'(side_overflow), 64'd0);
    side_write(32'h0000_0A06);
    check("R7 drop pulse", 64'(side_overflow), 64'd1);
    @(negedge clk);
    check("R7 pulse one cycle", 64'(side_overflow), 64'd0);
    for (int i = 1; i <= 5; i++) pop_expect("R6 side order", 32'h0000_0A00 + 32'(i), 1'b1);
    repeat (2) @(negedge clk);
    check("R7 dropped entry absent", 64'(out_valid), 64'd0);
    check("R11 free after drain", 64'(side_free), 64'd4);
  endtask

  task automatic t_wrap;
    for (int i = 7; i < 16; i++) ring_write(i, mk(1'b0, 19'(i), 1'b0, 1'b1, 5'(i), 1'b1, 4'(i)));
    for (int i = 7; i < 16; i++) pop_expect("R10 lap1", mk(1'b0, 19'(i), 1'b0, 1'b1, 5'(i), 1'b1, 4'(i)), 1'b0);
    repeat (3) @(negedge clk);
    check("R4 old gen1 stale after wrap", 64'(out_valid), 64'd0);
    ring_write(0, mk(1'b0, 19'h10000, 1'b0, 1'b0, 5'h11, 1'b0, 4'hA));
    pop_expect("R4 gen0 accepted on lap2", mk(1'b0, 19'h10000, 1'b0, 1'b0, 5'h11, 1'b0, 4'hA), 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 16; i++) ring_write(i, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ring_basic();
    t_stale_hold();
    t_backpressure();
    t_priority();
    t_overflow();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule